// File: doc/BRIEF.md
# Paired Watermark FIFO

This block holds two independent 16-entry word queues for a serial port. The transmit queue is filled by a processor or DMA engine and drained by the serial side. The receive queue is filled by the serial side and drained by the processor or DMA engine. Each queue drives a transfer request line. The request is raised when the queue's level meets a threshold set by a 3-bit watermark code. The transmit request counts free entries. The receive request counts stored entries.

Both queues report their level as a 5-bit count. Writes that would overrun a full queue and reads from an empty queue are recorded in sticky error flags, which software clears by writing ones. The serial shifter, frame timing and the DMA and interrupt controllers sit outside this block.

Top module: `wm_fifo_pair`

## Requirements
- R1: While reset is held, and on the first cycle after it, tx_free reads 16, rx_used reads 0, both requests read 0 and all four error flags read 0. Reset is synchronous and active low.
- R2: Each queue returns words in the order they were written. The oldest stored word is shown on the read-data port while the queue is not empty.
- R3: tx_free equals 16 minus the number of words in the transmit queue. rx_used equals the number of words in the receive queue. Both range from 0 to 16.
- R4: tx_req is 1 when free entries reach the threshold for tx_wm: 3'b000 needs 16, 3'b100 needs 12, 3'b101 needs 8, 3'b110 needs 4, and 3'b111 needs 1.
- R5: rx_req is 1 when stored entries reach the threshold for rx_wm: 3'b000 needs 1, 3'b100 needs 4, 3'b101 needs 8, 3'b110 needs 12, and 3'b111 needs 16.
- R6: Watermark codes 3'b001, 3'b010 and 3'b011 act exactly as 3'b000 on either queue.
- R7: A request is a registered output. It follows the level one clock after the level changes, and it drops when its threshold fails even if the queue is neither empty nor full.
- R8: A write to a full queue with no read in the same cycle is discarded. The level and stored words stay unchanged, and the queue's overflow flag (tx_ovf or rx_ovf) is set.
- R9: A read from an empty queue with no write in the same cycle shows zero on read data and leaves the queue unchanged. The queue's underflow flag (tx_udf or rx_udf) is set.
- R10: A write and a read in the same cycle on a full or an empty queue leave the level unchanged and set no flag. On an empty queue, read data shows the word being written.
- R11: The err_clr bits clear flags by writing one: bit 0 clears tx_ovf, bit 1 clears tx_udf, bit 2 clears rx_ovf, and bit 3 clears rx_udf. A new error in the same cycle wins over the clear. Flags whose err_clr bit is 0 are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_wm | input | 3 | Transmit watermark code |
| rx_wm | input | 3 | Receive watermark code |
| tx_wr_en | input | 1 | Push a word into the transmit queue |
| tx_wr_data | input | DW | Word to push into the transmit queue |
| tx_rd_en | input | 1 | Pop a word from the transmit queue |
| tx_rd_data | output | DW | Oldest transmit word |
| tx_free | output | 5 | Free transmit entries |
| tx_req | output | 1 | Transmit transfer request |
| rx_wr_en | input | 1 | Push a word into the receive queue |
| rx_wr_data | input | DW | Word to push into the receive queue |
| rx_rd_en | input | 1 | Pop a word from the receive queue |
| rx_rd_data | output | DW | Oldest receive word |
| rx_used | output | 5 | Stored receive entries |
| rx_req | output | 1 | Receive transfer request |
| err_clr | input | 4 | Write-one-to-clear for the error flags |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_udf | output | 1 | Sticky transmit underflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_udf | output | 1 | Sticky receive underflow |

## Verification
The hardest state to reach is a queue at an exact threshold boundary, where the request must differ between two levels one word apart. Each table vector resets the block and pushes an exact number of words. It then waits the one extra clock that the request register needs before sampling. The full-and-empty cases with a simultaneous push and pop take a queue filled to all 16 entries, then drive both strobes in one cycle. Read data is sampled before the edge and the level after it.

// File: rtl/wmfp_pkg.sv
package wmfp_pkg;

   localparam logic [2:0] WM_LOW  = 3'b100;
   localparam logic [2:0] WM_MID  = 3'b101;
   localparam logic [2:0] WM_HIGH = 3'b110;
   localparam logic [2:0] WM_TOP  = 3'b111;

   // Threshold in entries for a watermark code. free_side selects the
   // transmit ordering (free space) instead of the receive one (stored words).
   // Codes outside the four named ones fall back to the base setting.
   function automatic int unsigned wm_threshold(input logic [2:0] code,
                                                input bit free_side,
                                                input int unsigned depth);
      int unsigned q;
      q = depth / 4;
      case (code)
         WM_LOW:  return free_side ? 3 * q : q;
         WM_MID:  return 2 * q;
         WM_HIGH: return free_side ? q : 3 * q;
         WM_TOP:  return free_side ? 1 : depth;
         default: return free_side ? depth : 1;
      endcase
   endfunction

endpackage

// File: rtl/wmfp_lane.sv
module wmfp_lane #(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] count,
   output logic          ovf_evt,
   output logic          udf_evt
);

   initial begin
      assert (DEPTH >= 4 && (DEPTH % 4) == 0 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("wmfp_lane: DEPTH must be a power of two, at least 4");
      assert (DW >= 1) else $error("wmfp_lane: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt_q;
   logic          full, empty, wr_ok, rd_ok;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign wr_ok   = wr_en && (!full || rd_en);
   assign rd_ok   = rd_en && (!empty || wr_en);
   assign ovf_evt = wr_en && full && !rd_en;
   assign udf_evt = rd_en && empty && !wr_en;
   assign count   = cnt_q;

   // Head word; an empty queue shows the word being written, else zero.
   always_comb begin
      if (!empty)     rd_data = mem[rptr];
      else if (wr_en) rd_data = wr_data;
      else            rd_data = '0;
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_ok) wptr <= wptr + AW'(1);
         if (rd_ok) rptr <= rptr + AW'(1);
         if (wr_ok && !rd_ok)      cnt_q <= cnt_q + CW'(1);
         else if (rd_ok && !wr_ok) cnt_q <= cnt_q - CW'(1);
      end
   end

   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   a_r8_overflow_discard: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> (cnt_q == CW'(DEPTH)) && $stable(wptr));

   a_r9_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      udf_evt |=> (cnt_q == '0) && $stable(rptr));

   a_r10_both_keep_level: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && (full || empty)) |=> $stable(cnt_q));

endmodule

// File: rtl/wmfp_req.sv
module wmfp_req #(
   parameter int unsigned DEPTH     = 16,
   parameter bit          FREE_SIDE = 1'b1,
   localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    code,
   input  logic [CW-1:0] count,
   output logic          req
);

   logic [CW-1:0] level, thr;

   generate
      if (FREE_SIDE) begin : g_free
         assign level = CW'(DEPTH) - count;
      end else begin : g_used
         assign level = count;
      end
   endgenerate

   assign thr = CW'(wmfp_pkg::wm_threshold(code, FREE_SIDE, DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) req <= 1'b0;
      else        req <= (level >= thr);
   end

   a_r7_no_req_at_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(level) == '0) |-> !req);

endmodule

// File: rtl/wm_fifo_pair.sv
module wm_fifo_pair #(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    tx_wm,
   input  logic [2:0]    rx_wm,
   input  logic          tx_wr_en,
   input  logic [DW-1:0] tx_wr_data,
   input  logic          tx_rd_en,
   output logic [DW-1:0] tx_rd_data,
   output logic [4:0]    tx_free,
   output logic          tx_req,
   input  logic          rx_wr_en,
   input  logic [DW-1:0] rx_wr_data,
   input  logic          rx_rd_en,
   output logic [DW-1:0] rx_rd_data,
   output logic [4:0]    rx_used,
   output logic          rx_req,
   input  logic [3:0]    err_clr,
   output logic          tx_ovf,
   output logic          tx_udf,
   output logic          rx_ovf,
   output logic          rx_udf
);

   localparam int unsigned CW = $clog2(DEPTH + 1);

   initial begin
      assert (CW <= 5) else $error("wm_fifo_pair: level does not fit 5 bits");
   end

   logic [CW-1:0] tx_cnt, rx_cnt;
   logic          tx_ovf_e, tx_udf_e, rx_ovf_e, rx_udf_e;
   logic [3:0]    evt, flags;

   wmfp_lane #(.DW(DW), .DEPTH(DEPTH)) u_tx_lane (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tx_wr_en), .wr_data(tx_wr_data),
      .rd_en(tx_rd_en), .rd_data(tx_rd_data),
      .count(tx_cnt), .ovf_evt(tx_ovf_e), .udf_evt(tx_udf_e));

   wmfp_lane #(.DW(DW), .DEPTH(DEPTH)) u_rx_lane (
      .clk(clk), .rst_n(rst_n),
      .wr_en(rx_wr_en), .wr_data(rx_wr_data),
      .rd_en(rx_rd_en), .rd_data(rx_rd_data),
      .count(rx_cnt), .ovf_evt(rx_ovf_e), .udf_evt(rx_udf_e));

   wmfp_req #(.DEPTH(DEPTH), .FREE_SIDE(1'b1)) u_tx_req (
      .clk(clk), .rst_n(rst_n), .code(tx_wm), .count(tx_cnt), .req(tx_req));

   wmfp_req #(.DEPTH(DEPTH), .FREE_SIDE(1'b0)) u_rx_req (
      .clk(clk), .rst_n(rst_n), .code(rx_wm), .count(rx_cnt), .req(rx_req));

   assign tx_free = 5'(CW'(DEPTH) - tx_cnt);
   assign rx_used = 5'(rx_cnt);

   // Sticky flags: bit order tx_ovf, tx_udf, rx_ovf, rx_udf; set beats clear.
   assign evt = {rx_udf_e, rx_ovf_e, tx_udf_e, tx_ovf_e};

   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else begin
         for (int i = 0; i < 4; i++) begin
            if (evt[i])          flags[i] <= 1'b1;
            else if (err_clr[i]) flags[i] <= 1'b0;
         end
      end
   end

   assign tx_ovf = flags[0];
   assign tx_udf = flags[1];
   assign rx_ovf = flags[2];
   assign rx_udf = flags[3];

   a_r4_tx_full_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tx_free) == 5'd0) |-> !tx_req);

   a_r5_rx_empty_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rx_used) == 5'd0) |-> !rx_req);

   a_r8_ovf_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ovf_e |=> tx_ovf);

   a_r9_udf_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
      rx_udf_e |=> rx_udf);

   a_r11_clear_tx_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr[0] && !tx_ovf_e) |=> !tx_ovf);

   a_r1_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_free <= 5'(DEPTH)) && (rx_used <= 5'(DEPTH)));

endmodule

// File: tb/wm_fifo_pair_tb.sv
module wm_fifo_pair_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  tx_wm, rx_wm;
   logic        tx_wr_en, tx_rd_en, rx_wr_en, rx_rd_en;
   logic [15:0] tx_wr_data, rx_wr_data, tx_rd_data, rx_rd_data;
   logic [4:0]  tx_free, rx_used;
   logic        tx_req, rx_req;
   logic [3:0]  err_clr;
   logic        tx_ovf, tx_udf, rx_ovf, rx_udf;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   wm_fifo_pair #(.DW(16), .DEPTH(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .tx_wm(tx_wm), .rx_wm(rx_wm),
      .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_rd_en(tx_rd_en),
      .tx_rd_data(tx_rd_data), .tx_free(tx_free), .tx_req(tx_req),
      .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data), .rx_rd_en(rx_rd_en),
      .rx_rd_data(rx_rd_data), .rx_used(rx_used), .rx_req(rx_req),
      .err_clr(err_clr), .tx_ovf(tx_ovf), .tx_udf(tx_udf),
      .rx_ovf(rx_ovf), .rx_udf(rx_udf));

   // {is_rx, code[2:0], fill[4:0], expected request}
   localparam logic [9:0] VEC [24] = '{
      {1'b0, 3'b000, 5'd0,  1'b1}, {1'b0, 3'b000, 5'd1,  1'b0},
      {1'b0, 3'b100, 5'd4,  1'b1}, {1'b0, 3'b100, 5'd5,  1'b0},
      {1'b0, 3'b101, 5'd8,  1'b1}, {1'b0, 3'b101, 5'd9,  1'b0},
      {1'b0, 3'b110, 5'd12, 1'b1}, {1'b0, 3'b110, 5'd13, 1'b0},
      {1'b0, 3'b111, 5'd15, 1'b1}, {1'b0, 3'b111, 5'd16, 1'b0},
      {1'b0, 3'b010, 5'd0,  1'b1}, {1'b0, 3'b011, 5'd1,  1'b0},
      {1'b1, 3'b000, 5'd0,  1'b0}, {1'b1, 3'b000, 5'd1,  1'b1},
      {1'b1, 3'b100, 5'd3,  1'b0}, {1'b1, 3'b100, 5'd4,  1'b1},
      {1'b1, 3'b101, 5'd7,  1'b0}, {1'b1, 3'b101, 5'd8,  1'b1},
      {1'b1, 3'b110, 5'd11, 1'b0}, {1'b1, 3'b110, 5'd12, 1'b1},
      {1'b1, 3'b111, 5'd15, 1'b0}, {1'b1, 3'b111, 5'd16, 1'b1},
      {1'b1, 3'b001, 5'd1,  1'b1}, {1'b1, 3'b011, 5'd0,  1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic push(input bit rx, input int n, input logic [15:0] base);
      for (int k = 0; k < n; k++) begin
         if (rx) begin rx_wr_en = 1'b1; rx_wr_data = base + 16'(k); end
         else    begin tx_wr_en = 1'b1; tx_wr_data = base + 16'(k); end
         @(negedge clk);
      end
      rx_wr_en = 1'b0;
      tx_wr_en = 1'b0;
   endtask

   task automatic pop(input bit rx, input int n);
      for (int k = 0; k < n; k++) begin
         if (rx) rx_rd_en = 1'b1; else tx_rd_en = 1'b1;
         @(negedge clk);
      end
      rx_rd_en = 1'b0;
      tx_rd_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; tx_wm = 3'b000; rx_wm = 3'b000; err_clr = '0;
      tx_wr_en = 0; tx_rd_en = 0; rx_wr_en = 0; rx_rd_en = 0;
      tx_wr_data = '0; rx_wr_data = '0;
      @(negedge clk);
      @(negedge clk);

      // R1 reset state
      chk("R1 tx_free", 32'(tx_free), 32'd16);
      chk("R1 rx_used", 32'(rx_used), 32'd0);
      chk("R1 tx_req", 32'(tx_req), 32'd0);
      chk("R1 rx_req", 32'(rx_req), 32'd0);
      chk("R1 flags", 32'({tx_ovf, tx_udf, rx_ovf, rx_udf}), 32'd0);

      // R4 R5 R6 R3 threshold table
      for (int i = 0; i < 24; i++) begin
         automatic logic [9:0] e = VEC[i];
         automatic string tag = (e[8:6] inside {3'b001, 3'b010, 3'b011}) ? "R6" :
                                (e[9] ? "R5" : "R4");
         if (e[9]) rx_wm = e[8:6]; else tx_wm = e[8:6];
         do_reset();
         push(e[9], int'(e[5:1]), 16'h1000);
         @(negedge clk);
         if (e[9]) begin
            chk({tag, " rx_req"}, 32'(rx_req), 32'(e[0]));
            chk("R3 rx_used", 32'(rx_used), 32'(e[5:1]));
         end else begin
            chk({tag, " tx_req"}, 32'(tx_req), 32'(e[0]));
            chk("R3 tx_free", 32'(tx_free), 32'(5'd16 - e[5:1]));
         end
      end

      // R2 order
      tx_wm = 3'b000; rx_wm = 3'b000;
      do_reset();
      push(1'b0, 3, 16'h00A0);
      chk("R2 tx head 0", 32'(tx_rd_data), 32'h00A0);
      pop(1'b0, 1);
      chk("R2 tx head 1", 32'(tx_rd_data), 32'h00A1);
      pop(1'b0, 1);
      chk("R2 tx head 2", 32'(tx_rd_data), 32'h00A2);
      push(1'b1, 2, 16'h00C0);
      chk("R2 rx head 0", 32'(rx_rd_data), 32'h00C0);
      pop(1'b1, 1);
      chk("R2 rx head 1", 32'(rx_rd_data), 32'h00C1);

      // R7 registered request, drops with queue not empty
      rx_wm = 3'b100;
      do_reset();
      push(1'b1, 4, 16'h0010);
      @(negedge clk);
      chk("R7 rx_req at 4", 32'(rx_req), 32'd1);
      pop(1'b1, 1);
      chk("R7 rx_req lag", 32'(rx_req), 32'd1);
      @(negedge clk);
      chk("R7 rx_req drop", 32'(rx_req), 32'd0);
      chk("R7 rx_used", 32'(rx_used), 32'd3);

      // R9 underflow on empty receive queue
      rx_wm = 3'b000;
      do_reset();
      rx_rd_en = 1'b1;
      #1;
      chk("R9 rx_rd_data zero", 32'(rx_rd_data), 32'd0);
      @(negedge clk);
      rx_rd_en = 1'b0;
      chk("R9 rx_udf", 32'(rx_udf), 32'd1);
      chk("R9 rx_used", 32'(rx_used), 32'd0);
      push(1'b1, 1, 16'h003C);
      chk("R9 rx head after", 32'(rx_rd_data), 32'h003C);
      chk("R9 rx_used after", 32'(rx_used), 32'd1);

      // R8 overflow on full transmit queue
      push(1'b0, 16, 16'h0100);
      push(1'b0, 1, 16'h0BAD);
      chk("R8 tx_ovf", 32'(tx_ovf), 32'd1);
      chk("R8 tx_free", 32'(tx_free), 32'd0);
      chk("R8 tx head", 32'(tx_rd_data), 32'h0100);
      chk("R8 rx_ovf", 32'(rx_ovf), 32'd0);
      pop(1'b0, 15);
      chk("R8 tx last", 32'(tx_rd_data), 32'h010F);
      chk("R8 tx_free after", 32'(tx_free), 32'd15);

      // R11 write-one-to-clear
      err_clr = 4'b0001;
      @(negedge clk);
      err_clr = 4'b0000;
      chk("R11 tx_ovf cleared", 32'(tx_ovf), 32'd0);
      chk("R11 rx_udf kept", 32'(rx_udf), 32'd1);
      err_clr = 4'b1000;
      @(negedge clk);
      err_clr = 4'b0000;
      chk("R11 rx_udf cleared", 32'(rx_udf), 32'd0);
      rx_wr_en = 1'b0;
      tx_rd_en = 1'b1;
      tx_rd_en = 1'b0;

      // R10 simultaneous push and pop on full and empty queues
      do_reset();
      push(1'b0, 16, 16'h0200);
      tx_wr_en = 1'b1; tx_rd_en = 1'b1; tx_wr_data = 16'h0055;
      @(negedge clk);
      tx_wr_en = 1'b0; tx_rd_en = 1'b0;
      chk("R10 tx_free", 32'(tx_free), 32'd0);
      chk("R10 tx flags", 32'({tx_ovf, tx_udf}), 32'd0);
      chk("R10 tx head", 32'(tx_rd_data), 32'h0201);
      rx_wr_en = 1'b1; rx_rd_en = 1'b1; rx_wr_data = 16'h0077;
      #1;
      chk("R10 rx pass", 32'(rx_rd_data), 32'h0077);
      @(negedge clk);
      rx_wr_en = 1'b0; rx_rd_en = 1'b0;
      chk("R10 rx_used", 32'(rx_used), 32'd0);
      chk("R10 rx flags", 32'({rx_ovf, rx_udf}), 32'd0);

      finish_run();
   end

endmodule